// File: doc/BRIEF.md
# Bit-Addressable Data Memory Unit

This block serves the data side of a small 8-bit controller core. It holds the internal scratch RAM (128 or 256 bytes) and a sparse set of special-function registers that share the upper half of the direct byte space. The core issues one operation per cycle: byte read or write, working-register read or write relative to the current bank, or bit set, clear or test through an 8-bit bit address. The bit address reaches either the bit-addressable RAM window or a bit-addressable register.

Results come back one clock after the request. Each response says whether the address exists. Registers with only some bits implemented keep only those bits, and the missing bits read back as a fixed filler pattern. A read of a write-only register returns the filler and raises an error flag. Port registers return the external pins on plain reads and the output latch on read-modify-write accesses. Two side effects are exported. A write to the serial buffer address pulses a transmit-start strobe and loads the transmit byte. A write to one of the interrupt configuration registers sets a flag that tells the interrupt logic to hold off for one instruction.

Top module: `dmem_unit`

## Requirements
- R1: Operation codes are NOP=0, RD=1, WR=2, BSET=3, BCLR=4, BTST=5, RRD=6, RWR=7. A direct (indirect=0) RD or WR at an address below 0x80 accesses RAM, and the RD result appears on rdata one cycle after the request.
- R2: A direct byte access at 0x80 or above targets the register space and is valid only for an implemented register (0x80, 0x81, 0x87, 0x88, 0x90, 0x99, 0xA6, 0xA8, 0xB7, 0xB8, 0xD0, 0xE0). An indirect byte access always targets RAM and is valid when the address is below the RAM size (256 by default), so indirect 0x80 is a RAM byte separate from the register at 0x80.
- R3: A bit address b below 128 selects RAM byte 0x20 + b/8. A bit address of 128 or more selects the register at b with its low three bits cleared. In both cases the bit position is b mod 8.
- R4: BSET and BCLR change only the selected bit and leave the other seven bits unchanged. BTST returns the selected bit on rbit and the containing byte on rdata.
- R5: RRD and RWR take the register number n from addr[2:0] and access RAM byte bank*8 + n, with bank in 0..3.
- R6: Partly implemented registers (0x87 mask 0x8F, 0xA8 mask 0x9F, 0xB7 mask 0x7F, 0xB8 mask 0x3F) store wdata AND mask. A read returns (stored AND mask) OR (NOT mask AND 0xA5).
- R7: A read of the write-only register 0xA6 returns 0xA5 with wo_err high and addr_err low in the response cycle.
- R8: A valid write to 0x99 loads tx_data, pulses tx_start for exactly the response cycle, leaves the register's stored value unchanged (it reads 0x00 after reset), and leaves skip_irq unchanged.
- R9: skip_irq goes high after any valid register write (byte or bit) to 0xA8, 0xB8 or 0xB7. It goes low after any other valid register write except 0x99. RAM writes leave it unchanged.
- R10: The port registers 0x80 (pins[7:0]) and 0x90 (pins[15:8]) return the pins when rmw=0 and the latch when rmw=1. BSET and BCLR always modify the latch.
- R11: An invalid access raises addr_err in its response cycle with rdata 0xA5. It changes no RAM, register, tx_data or skip_irq, and produces no tx_start.
- R12: Bit addresses 0xAE and 0xD1 are restricted: any bit operation on them is invalid.
- R13: After reset, rdata, rbit, addr_err, wo_err, tx_start and skip_irq are 0, RAM reads 0x00, the port latches read 0xFF, 0x81 reads 0x07 and the other registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code for this cycle |
| addr | input | 8 | Byte address, bit address, or register number in bits 2:0 |
| wdata | input | 8 | Write data for byte and register writes |
| indirect | input | 1 | Byte access uses indirect addressing |
| rmw | input | 1 | Access is part of a read-modify-write (port latch view) |
| bank | input | 2 | Current working register bank |
| pins | input | 16 | External pin levels of the two ports |
| rdata | output | 8 | Read result, one cycle after the request |
| rbit | output | 1 | Bit test result |
| addr_err | output | 1 | Request addressed unimplemented space |
| wo_err | output | 1 | Request read a write-only register |
| tx_start | output | 1 | One-cycle transmit start strobe |
| tx_data | output | 8 | Last byte written to the serial buffer |
| skip_irq | output | 1 | Hold off the next interrupt |

## Verification
A wrong address split shows up as data that lands in the wrong byte. The damage appears on rdata at the first later read of either the intended byte or the one actually hit, so each write is read back both through its own path and through an aliasing path (indirect against direct, bit against byte, bank register against direct). Mask, filler and port-view errors show on the very next response. The flags addr_err, wo_err, tx_start and skip_irq are compared in the response cycle of every operation that could move them, and a failure to suppress a write shows as a wrong read one request later.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_BSET = 3'd3,
    OP_BCLR = 3'd4,
    OP_BTST = 3'd5,
    OP_RRD  = 3'd6,
    OP_RWR  = 3'd7
  } dm_op_e;

  // Default register table, entry 0 in the least significant byte.
  localparam int DEF_N_SFR = 12;
  localparam logic [DEF_N_SFR*8-1:0] DEF_SFR_ADDR = {
    8'hE0, 8'hD0, 8'hB8, 8'hB7, 8'hA8, 8'hA6,
    8'h99, 8'h90, 8'h88, 8'h87, 8'h81, 8'h80};
  localparam logic [DEF_N_SFR*8-1:0] DEF_SFR_MASK = {
    8'hFF, 8'hFF, 8'h3F, 8'h7F, 8'h9F, 8'hFF,
    8'hFF, 8'hFF, 8'hFF, 8'h8F, 8'hFF, 8'hFF};
  localparam logic [DEF_N_SFR*8-1:0] DEF_SFR_RST = {
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h00, 8'hFF, 8'h00, 8'h00, 8'h07, 8'hFF};
  localparam logic [DEF_N_SFR-1:0] DEF_SFR_WO = 12'h040;

  localparam int DEF_N_PORT = 2;
  localparam logic [DEF_N_PORT*8-1:0] DEF_PORT_ADDR = {8'h90, 8'h80};

  localparam int DEF_N_RBIT = 2;
  localparam logic [DEF_N_RBIT*8-1:0] DEF_RBIT = {8'hD1, 8'hAE};

  // Byte that holds a given bit address.
  function automatic logic [7:0] bit_home(input logic [7:0] ba);
    return ba[7] ? {ba[7:3], 3'b000} : (8'h20 + {4'b0000, ba[6:3]});
  endfunction

  // RAM byte of working register n in a bank.
  function automatic logic [7:0] reg_home(input logic [1:0] bank, input logic [2:0] n);
    return {3'b000, bank, n};
  endfunction

  // Byte with one bit forced to a value.
  function automatic logic [7:0] bit_write(input logic [7:0] b, input logic [2:0] pos,
                                           input logic v);
    logic [7:0] r;
    r = b;
    r[pos] = v;
    return r;
  endfunction

  // Stored bits where implemented, filler elsewhere.
  function automatic logic [7:0] fill_unimpl(input logic [7:0] stored, input logic [7:0] mask,
                                             input logic [7:0] fill);
    return (stored & mask) | (~mask & fill);
  endfunction

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int RAM_SIZE = 256,
  parameter int N_RBIT = DEF_N_RBIT,
  parameter logic [N_RBIT*8-1:0] RBIT_LIST = DEF_RBIT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dm_op_e     op,
  input  logic [7:0] addr,
  input  logic       indirect,
  input  logic [1:0] bank,
  input  logic       sfr_impl,
  output logic [7:0] tgt_addr,
  output logic       tgt_sfr,
  output logic [2:0] bit_pos,
  output logic       is_bit,
  output logic       is_read,
  output logic       is_write,
  output logic       acc_valid
);

  logic [N_RBIT-1:0] rb_hit;
  logic              restricted;

  for (genvar g = 0; g < N_RBIT; g++) begin : g_rbit
    assign rb_hit[g] = (addr == RBIT_LIST[g*8 +: 8]);
  end
  assign restricted = |rb_hit;

  // Target selection.
  always_comb begin
    tgt_addr = addr;
    tgt_sfr  = 1'b0;
    bit_pos  = addr[2:0];
    is_bit   = 1'b0;
    is_read  = 1'b0;
    is_write = 1'b0;
    unique case (op)
      OP_RD, OP_WR: begin
        tgt_sfr  = !indirect && addr[7];
        is_read  = (op == OP_RD);
        is_write = (op == OP_WR);
      end
      OP_BSET, OP_BCLR, OP_BTST: begin
        tgt_addr = bit_home(addr);
        tgt_sfr  = addr[7];
        is_bit   = 1'b1;
        is_read  = (op == OP_BTST);
        is_write = (op != OP_BTST);
      end
      OP_RRD, OP_RWR: begin
        tgt_addr = reg_home(bank, addr[2:0]);
        is_read  = (op == OP_RRD);
        is_write = (op == OP_RWR);
      end
      default: ;
    endcase
  end

  // Validity, kept apart from target selection.
  always_comb begin
    acc_valid = 1'b0;
    unique case (op)
      OP_RD, OP_WR:              acc_valid = tgt_sfr ? sfr_impl : (int'(addr) < RAM_SIZE);
      OP_BSET, OP_BCLR, OP_BTST: acc_valid = !restricted &&
                                             (tgt_sfr ? sfr_impl : (int'(tgt_addr) < RAM_SIZE));
      OP_RRD, OP_RWR:            acc_valid = 1'b1;
      default:                   acc_valid = 1'b0;
    endcase
  end

  p_reg_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RRD || op == OP_RWR) |-> (tgt_addr[7:5] == 3'b000) && !tgt_sfr && acc_valid);

  p_bit_ram_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bit && !addr[7]) |-> (tgt_addr[7:4] == 4'h2) && !tgt_sfr);

  p_restricted_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bit && restricted) |-> !acc_valid);

endmodule

// File: rtl/dmem_iram.sv
module dmem_iram #(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] idx;

  assign idx = addr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

  p_ram_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> mem[$past(idx)] == $past(rdata));

endmodule

// File: rtl/dmem_sfr_file.sv
module dmem_sfr_file
  import dmem_pkg::*;
#(
  parameter int N_SFR = DEF_N_SFR,
  parameter logic [N_SFR*8-1:0] SFR_ADDR = DEF_SFR_ADDR,
  parameter logic [N_SFR*8-1:0] SFR_MASK = DEF_SFR_MASK,
  parameter logic [N_SFR*8-1:0] SFR_RST = DEF_SFR_RST,
  parameter logic [N_SFR-1:0]   SFR_WO = DEF_SFR_WO,
  parameter int N_PORT = DEF_N_PORT,
  parameter logic [N_PORT*8-1:0] PORT_ADDR = DEF_PORT_ADDR,
  parameter logic [7:0] SBUF_ADDR = 8'h99,
  parameter logic [7:0] IE_ADDR = 8'hA8,
  parameter logic [7:0] IP_ADDR = 8'hB8,
  parameter logic [7:0] IPH_ADDR = 8'hB7,
  parameter logic [7:0] FILL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  input  logic              we,
  input  logic [7:0]        wdata,
  input  logic              rmw,
  input  logic [N_PORT*8-1:0] pins,
  output logic              impl,
  output logic [7:0]        rd_val,
  output logic [7:0]        latch_val,
  output logic              wo_hit,
  output logic              tx_load,
  output logic [7:0]        tx_data,
  output logic              skip_irq
);

  logic [N_SFR-1:0]   hit;
  logic [N_SFR*8-1:0] store_flat;
  logic [N_PORT-1:0]  pin_hit;
  logic               cfg_hit;
  logic [7:0]         stored_sel, mask_sel, pin_sel;

  assign tx_load = we && (addr == SBUF_ADDR);
  assign cfg_hit = (addr == IE_ADDR) || (addr == IP_ADDR) || (addr == IPH_ADDR);

  for (genvar i = 0; i < N_SFR; i++) begin : g_sfr
    localparam logic [7:0] MASK = SFR_MASK[i*8 +: 8];
    logic [7:0] q;

    assign hit[i] = (addr == SFR_ADDR[i*8 +: 8]);

    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= SFR_RST[i*8 +: 8] & MASK;
      else if (we && hit[i] && !tx_load) q <= wdata & MASK;
    end

    assign store_flat[i*8 +: 8] = q;

    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~MASK) == 8'h00);
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    assign pin_hit[p] = (addr == PORT_ADDR[p*8 +: 8]);
  end

  always_comb begin
    stored_sel = 8'h00;
    mask_sel   = 8'hFF;
    pin_sel    = 8'h00;
    for (int i = 0; i < N_SFR; i++) begin
      if (hit[i]) begin
        stored_sel = store_flat[i*8 +: 8];
        mask_sel   = SFR_MASK[i*8 +: 8];
      end
    end
    for (int p = 0; p < N_PORT; p++) begin
      if (pin_hit[p]) pin_sel = pins[p*8 +: 8];
    end
  end

  assign impl      = |hit;
  assign wo_hit    = |(hit & SFR_WO);
  assign latch_val = stored_sel;

  always_comb begin
    if (wo_hit)                 rd_val = FILL;
    else if (|pin_hit && !rmw)  rd_val = pin_sel;
    else                        rd_val = fill_unimpl(stored_sel, mask_sel, FILL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data  <= 8'h00;
      skip_irq <= 1'b0;
    end else begin
      if (tx_load)       tx_data  <= wdata;
      if (we && !tx_load) skip_irq <= cfg_hit;
    end
  end

  p_cfg_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && cfg_hit && !tx_load) |=> skip_irq);

  p_sbuf_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> $stable(skip_irq));

  p_txdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_data == $past(wdata));

  p_idle_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(skip_irq) && $stable(tx_data));

endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
  import dmem_pkg::*;
#(
  parameter int RAM_SIZE = 256,
  parameter int N_SFR = DEF_N_SFR,
  parameter logic [N_SFR*8-1:0] SFR_ADDR = DEF_SFR_ADDR,
  parameter logic [N_SFR*8-1:0] SFR_MASK = DEF_SFR_MASK,
  parameter logic [N_SFR*8-1:0] SFR_RST = DEF_SFR_RST,
  parameter logic [N_SFR-1:0]   SFR_WO = DEF_SFR_WO,
  parameter int N_PORT = DEF_N_PORT,
  parameter logic [N_PORT*8-1:0] PORT_ADDR = DEF_PORT_ADDR,
  parameter int N_RBIT = DEF_N_RBIT,
  parameter logic [N_RBIT*8-1:0] RBIT_LIST = DEF_RBIT,
  parameter logic [7:0] SBUF_ADDR = 8'h99,
  parameter logic [7:0] IE_ADDR = 8'hA8,
  parameter logic [7:0] IP_ADDR = 8'hB8,
  parameter logic [7:0] IPH_ADDR = 8'hB7,
  parameter logic [7:0] FILL = 8'hA5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op,
  input  logic [7:0]          addr,
  input  logic [7:0]          wdata,
  input  logic                indirect,
  input  logic                rmw,
  input  logic [1:0]          bank,
  input  logic [N_PORT*8-1:0] pins,
  output logic [7:0]          rdata,
  output logic                rbit,
  output logic                addr_err,
  output logic                wo_err,
  output logic                tx_start,
  output logic [7:0]          tx_data,
  output logic                skip_irq
);

  dm_op_e     op_e;
  logic [7:0] tgt_addr;
  logic       tgt_sfr, is_bit, is_read, is_write, acc_valid;
  logic [2:0] bit_pos;
  logic       sfr_impl, sfr_wo, tx_load;
  logic [7:0] ram_rd, sfr_rd, sfr_latch;
  logic [7:0] byte_rd, base_byte, wr_val;
  logic       req, wr_en, ram_we, sfr_we, wo_read;

  assign op_e = dm_op_e'(op);

  dmem_decode #(
    .RAM_SIZE (RAM_SIZE),
    .N_RBIT   (N_RBIT),
    .RBIT_LIST(RBIT_LIST)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op_e),
    .addr     (addr),
    .indirect (indirect),
    .bank     (bank),
    .sfr_impl (sfr_impl),
    .tgt_addr (tgt_addr),
    .tgt_sfr  (tgt_sfr),
    .bit_pos  (bit_pos),
    .is_bit   (is_bit),
    .is_read  (is_read),
    .is_write (is_write),
    .acc_valid(acc_valid)
  );

  dmem_iram #(
    .DEPTH(RAM_SIZE)
  ) u_iram (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ram_we),
    .addr (tgt_addr),
    .wdata(wr_val),
    .rdata(ram_rd)
  );

  dmem_sfr_file #(
    .N_SFR    (N_SFR),
    .SFR_ADDR (SFR_ADDR),
    .SFR_MASK (SFR_MASK),
    .SFR_RST  (SFR_RST),
    .SFR_WO   (SFR_WO),
    .N_PORT   (N_PORT),
    .PORT_ADDR(PORT_ADDR),
    .SBUF_ADDR(SBUF_ADDR),
    .IE_ADDR  (IE_ADDR),
    .IP_ADDR  (IP_ADDR),
    .IPH_ADDR (IPH_ADDR),
    .FILL     (FILL)
  ) u_sfr (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (tgt_addr),
    .we       (sfr_we),
    .wdata    (wr_val),
    .rmw      (rmw),
    .pins     (pins),
    .impl     (sfr_impl),
    .rd_val   (sfr_rd),
    .latch_val(sfr_latch),
    .wo_hit   (sfr_wo),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .skip_irq (skip_irq)
  );

  // Read view honours the port pin/latch choice; bit writes start from storage.
  assign byte_rd   = tgt_sfr ? sfr_rd : ram_rd;
  assign base_byte = tgt_sfr ? sfr_latch : ram_rd;
  assign wr_val    = is_bit ? bit_write(base_byte, bit_pos, op_e == OP_BSET) : wdata;

  assign req     = (op_e != OP_NOP);
  assign wr_en   = acc_valid && is_write;
  assign ram_we  = wr_en && !tgt_sfr;
  assign sfr_we  = wr_en && tgt_sfr;
  assign wo_read = acc_valid && is_read && tgt_sfr && sfr_wo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= 8'h00;
      rbit     <= 1'b0;
      addr_err <= 1'b0;
      wo_err   <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      addr_err <= req && !acc_valid;
      wo_err   <= wo_read;
      tx_start <= tx_load;
      rbit     <= acc_valid && (op_e == OP_BTST) && byte_rd[bit_pos];
      if (!req)            rdata <= 8'h00;
      else if (!acc_valid) rdata <= FILL;
      else if (is_read)    rdata <= byte_rd;
      else                 rdata <= 8'h00;
    end
  end

  p_err_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !acc_valid) |=> addr_err && !tx_start && !wo_err && (rdata == FILL));

  p_wo_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wo_read |=> wo_err && !addr_err && (rdata == FILL));

  p_bit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && is_bit) |-> $countones(wr_val ^ ram_rd) <= 1);

  p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_start && !addr_err);

  p_err_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !wo_err);

endmodule

// File: tb/dmem_unit_tb.sv
module dmem_unit_tb;
  import dmem_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic        indirect = 1'b0;
  logic        rmw = 1'b0;
  logic [1:0]  bank = 2'd0;
  logic [15:0] pins = 16'h0000;
  logic [7:0]  rdata, tx_data;
  logic        rbit, addr_err, wo_err, tx_start, skip_irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  dmem_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .wdata(wdata),
    .indirect(indirect), .rmw(rmw), .bank(bank), .pins(pins),
    .rdata(rdata), .rbit(rbit), .addr_err(addr_err), .wo_err(wo_err),
    .tx_start(tx_start), .tx_data(tx_data), .skip_irq(skip_irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Drive one request at a falling edge; return at the next falling edge,
  // where the response of that request is on the outputs.
  task automatic issue(input logic [2:0] o, input logic [7:0] a, input logic [7:0] d,
                       input logic ind = 1'b0, input logic m = 1'b0);
    op = o; addr = a; wdata = d; indirect = ind; rmw = m;
    @(negedge clk);
    op = 3'd0; indirect = 1'b0; rmw = 1'b0;
  endtask

  task automatic t_reset;
    chk("R13 rdata", rdata, 8'h00);
    chk("R13 flags", {rbit, addr_err, wo_err, tx_start, skip_irq}, 5'b0);
    issue(OP_RD, 8'h80, 8'h00, 1'b0, 1'b1);
    chk("R13 port latch", rdata, 8'hFF);
    issue(OP_RD, 8'h81, 8'h00);
    chk("R13 stack reg", rdata, 8'h07);
    issue(OP_RD, 8'h45, 8'h00);
    chk("R13 ram", rdata, 8'h00);
  endtask

  task automatic t_ram;
    issue(OP_WR, 8'h30, 8'h3C);
    issue(OP_WR, 8'h7F, 8'hC3);
    issue(OP_RD, 8'h30, 8'h00);
    chk("R1 read 0x30", rdata, 8'h3C);
    chk("R1 no error", addr_err, 1'b0);
    issue(OP_RD, 8'h7F, 8'h00);
    chk("R1 read 0x7F", rdata, 8'hC3);
  endtask

  task automatic t_indirect;
    issue(OP_WR, 8'h80, 8'h11, 1'b1);
    issue(OP_RD, 8'h80, 8'h00, 1'b0, 1'b1);
    chk("R2 direct 0x80 untouched", rdata, 8'hFF);
    issue(OP_RD, 8'h80, 8'h00, 1'b1);
    chk("R2 indirect 0x80", rdata, 8'h11);
    issue(OP_WR, 8'hFF, 8'hEE, 1'b1);
    issue(OP_RD, 8'hFF, 8'h00, 1'b1);
    chk("R2 indirect 0xFF", rdata, 8'hEE);
    chk("R2 indirect valid", addr_err, 1'b0);
    issue(OP_RD, 8'h85, 8'h00);
    chk("R2 unimplemented direct", addr_err, 1'b1);
  endtask

  task automatic t_bits;
    issue(OP_WR, 8'h21, 8'h00);
    issue(OP_BSET, 8'h0B, 8'h00);
    issue(OP_RD, 8'h21, 8'h00);
    chk("R3 bit 0x0B -> 0x21.3", rdata, 8'h08);
    issue(OP_WR, 8'h2F, 8'hFF);
    issue(OP_BCLR, 8'h7F, 8'h00);
    issue(OP_RD, 8'h2F, 8'h00);
    chk("R4 clear keeps others", rdata, 8'h7F);
    issue(OP_WR, 8'h20, 8'h5A);
    issue(OP_BSET, 8'h00, 8'h00);
    issue(OP_RD, 8'h20, 8'h00);
    chk("R4 set keeps others", rdata, 8'h5B);
    issue(OP_BTST, 8'h0B, 8'h00);
    chk("R4 test set bit", rbit, 1'b1);
    chk("R4 test byte", rdata, 8'h08);
    issue(OP_BTST, 8'h0A, 8'h00);
    chk("R4 test clear bit", rbit, 1'b0);
    issue(OP_WR, 8'hE0, 8'h00);
    issue(OP_BSET, 8'hE5, 8'h00);
    issue(OP_RD, 8'hE0, 8'h00);
    chk("R3 register bit 0xE5", rdata, 8'h20);
  endtask

  task automatic t_regs;
    bank = 2'd2;
    issue(OP_RWR, 8'h03, 8'h77);
    bank = 2'd3;
    issue(OP_RWR, 8'h07, 8'h9C);
    bank = 2'd0;
    issue(OP_RD, 8'h13, 8'h00);
    chk("R5 bank2 R3", rdata, 8'h77);
    issue(OP_RD, 8'h1F, 8'h00);
    chk("R5 bank3 R7", rdata, 8'h9C);
    bank = 2'd2;
    issue(OP_RRD, 8'h03, 8'h00);
    chk("R5 register read", rdata, 8'h77);
    bank = 2'd0;
  endtask

  task automatic t_partial;
    issue(OP_WR, 8'h87, 8'hFF);
    issue(OP_RD, 8'h87, 8'h00);
    chk("R6 mask 0x8F", rdata, 8'hAF);
    issue(OP_WR, 8'hB8, 8'h15);
    issue(OP_RD, 8'hB8, 8'h00);
    chk("R6 mask 0x3F", rdata, 8'h95);
  endtask

  task automatic t_wo;
    issue(OP_WR, 8'hA6, 8'h12);
    chk("R7 write ok", addr_err, 1'b0);
    issue(OP_RD, 8'hA6, 8'h00);
    chk("R7 filler", rdata, 8'hA5);
    chk("R7 flag", wo_err, 1'b1);
    chk("R7 no addr error", addr_err, 1'b0);
    issue(OP_RD, 8'h81, 8'h00);
    chk("R7 flag clears", wo_err, 1'b0);
  endtask

  task automatic t_sbuf;
    issue(OP_WR, 8'hA8, 8'h01);
    issue(OP_WR, 8'h99, 8'h5C);
    chk("R8 strobe", tx_start, 1'b1);
    chk("R8 tx byte", tx_data, 8'h5C);
    chk("R8 skip kept", skip_irq, 1'b1);
    issue(OP_RD, 8'h99, 8'h00);
    chk("R8 single pulse", tx_start, 1'b0);
    chk("R8 storage unchanged", rdata, 8'h00);
  endtask

  task automatic t_skip;
    issue(OP_WR, 8'hE0, 8'h00);
    chk("R9 other clears", skip_irq, 1'b0);
    issue(OP_WR, 8'hB8, 8'h00);
    chk("R9 priority sets", skip_irq, 1'b1);
    issue(OP_WR, 8'hE0, 8'h00);
    issue(OP_WR, 8'hB7, 8'h00);
    chk("R9 high priority sets", skip_irq, 1'b1);
    issue(OP_WR, 8'h30, 8'h01);
    chk("R9 ram write keeps", skip_irq, 1'b1);
    issue(OP_BSET, 8'hD5, 8'h00);
    chk("R9 bit write clears", skip_irq, 1'b0);
    issue(OP_BSET, 8'hAF, 8'h00);
    chk("R9 bit write to enable sets", skip_irq, 1'b1);
  endtask

  task automatic t_port;
    pins = 16'h3C00;
    issue(OP_RD, 8'h90, 8'h00);
    chk("R10 pins", rdata, 8'h3C);
    issue(OP_RD, 8'h90, 8'h00, 1'b0, 1'b1);
    chk("R10 latch", rdata, 8'hFF);
    issue(OP_BCLR, 8'h90, 8'h00);
    issue(OP_RD, 8'h90, 8'h00, 1'b0, 1'b1);
    chk("R10 latch after clear", rdata, 8'hFE);
    issue(OP_RD, 8'h90, 8'h00);
    chk("R10 pins unchanged", rdata, 8'h3C);
    issue(OP_BTST, 8'h91, 8'h00);
    chk("R10 bit test pin", rbit, 1'b0);
    issue(OP_BTST, 8'h91, 8'h00, 1'b0, 1'b1);
    chk("R10 bit test latch", rbit, 1'b1);
  endtask

  task automatic t_invalid;
    issue(OP_WR, 8'h30, 8'h66);
    issue(OP_WR, 8'hA8, 8'h01);
    issue(OP_WR, 8'h85, 8'h99);
    chk("R11 error", addr_err, 1'b1);
    chk("R11 filler", rdata, 8'hA5);
    chk("R11 no strobe", tx_start, 1'b0);
    chk("R11 skip kept", skip_irq, 1'b1);
    issue(OP_BSET, 8'hC3, 8'h00);
    chk("R11 bit in missing reg", addr_err, 1'b1);
    issue(OP_RD, 8'h30, 8'h00);
    chk("R11 error clears", addr_err, 1'b0);
    chk("R11 ram intact", rdata, 8'h66);
  endtask

  task automatic t_restricted;
    issue(OP_WR, 8'hD0, 8'h00);
    issue(OP_BSET, 8'hD1, 8'h00);
    chk("R12 0xD1 invalid", addr_err, 1'b1);
    issue(OP_RD, 8'hD0, 8'h00);
    chk("R12 status unchanged", rdata, 8'h00);
    issue(OP_BSET, 8'hD2, 8'h00);
    chk("R12 neighbour valid", addr_err, 1'b0);
    issue(OP_RD, 8'hD0, 8'h00);
    chk("R12 neighbour set", rdata, 8'h04);
    issue(OP_WR, 8'hA8, 8'h00);
    issue(OP_BSET, 8'hAE, 8'h00);
    chk("R12 0xAE invalid", addr_err, 1'b1);
    issue(OP_RD, 8'hA8, 8'h00);
    chk("R12 enable reg unchanged", rdata, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram();
    t_indirect();
    t_bits();
    t_regs();
    t_partial();
    t_wo();
    t_sbuf();
    t_skip();
    t_port();
    t_invalid();
    t_restricted();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule